// File: doc/BRIEF.md
# MSI to memory ring controller

The block turns message-signalled interrupt writes into records in a circular queue that lives in system memory, and raises a level interrupt towards the host processor while unread records remain. Each accepted message becomes one 16-byte record. The record goes out as a single 128-bit write on a valid/ready memory request port. Its address is the 64-bit queue base plus the current write offset.

Software sets up the block through a small register port. It programs the queue base, the queue size and the control bits. It consumes records by advancing the read offset it keeps in a register. The queue size is picked at run time from four power-of-two sizes between 32 KB and 256 KB. When the queue would become full, the block can either drop new messages and latch an overflow flag, or overwrite the oldest record. Only one memory write is in flight at a time, and the message input is held off with a ready signal while that write is pending.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and no memory request is active.
- R2: While control bit 0 (enable) is clear, an offered message is consumed without any memory write and without changing the write offset, and `irq_o` stays low.
- R3: The register offsets are 0 for control, 3 for base bits 63:32, 4 for base bits 31:0, 5 for the read offset and 6 for the write offset. The base registers read back as written, and an unused offset reads zero.
- R4: Each message is written as one beat at address base + write offset. Beat bits 31:0 hold the 32-bit message data, least significant byte in the lowest lane, and bits 127:32 are zero.
- R5: The write offset advances by 16 only in the cycle that the memory handshake completes. While a request waits, `mem_valid_o`, the address and the data hold steady and `msi_ready_o` is low.
- R6: Control bits 9:8 hold n, and the queue size is 2^(15+n) bytes. Offsets are 16-byte aligned. Writes to either offset are masked to the current size, and the write offset reads back masked to the current size. Advancing past the last slot wraps to 0.
- R7: `irq_o` is high exactly when enable (bit 0) and interrupt enable (bit 3) are set and the read offset differs from the write offset.
- R8: With full detection (bit 1) and stop-on-full (bit 4) set, a message that arrives when (write offset + 16) mod size equals the read offset is dropped, and the sticky overflow flag (control bit 31) is set. Writing control with bit 31 set clears the flag.
- R9: With full detection set and stop-on-full clear, a message that arrives on a full queue is written, and the read offset advances by 16 together with the write offset.
- R10: With full detection clear, a message is always written and the read offset is left unchanged, even if the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from `reg_addr_i`) |
| msi_valid_i | input | 1 | Message offered |
| msi_data_i | input | 32 | Message data word |
| msi_ready_o | output | 1 | Block can take a message this cycle |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 64 | Byte address of the record |
| mem_data_o | output | 128 | Record contents |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
A message taken at clock edge k drives `mem_valid_o` after that edge. With memory ready, the handshake falls at edge k+1, where the write offset and `irq_o` change. A drop sets the overflow flag at edge k itself. Register writes show up in read data and in `irq_o` one edge after the strobe. The bench drives inputs on falling edges and samples on the falling edge after the edge where each result is due. In the stall test it samples on every falling edge while ready is held low, to confirm that nothing moves until ready returns.

// File: rtl/msi_ring_pkg.sv
`timescale 1ns/1ps
package msi_ring_pkg;
  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_BASE_HI = 3'd3;
  localparam logic [2:0] REG_BASE_LO = 3'd4;
  localparam logic [2:0] REG_RD_OFS  = 3'd5;
  localparam logic [2:0] REG_WR_OFS  = 3'd6;

  typedef struct packed {
    logic       ovf;
    logic [1:0] size;
    logic       stop;
    logic       irq_en;
    logic       full_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/msi_ring_regs.sv
`timescale 1ns/1ps
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 64,
  parameter int unsigned OFS_W        = 18,
  parameter int unsigned ENTRY_LOG    = 4,
  parameter int unsigned SIZE_MIN_LOG = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              full_en_o,
  output logic              stop_o,
  output logic              irq_en_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFS_W-1:0]  mask_o,
  output logic [OFS_W-1:0]  rd_off_o,
  output logic [OFS_W-1:0]  wr_off_o,
  input  logic              adv_i,
  input  logic              ovw_i,
  input  logic              drop_i
);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(1 << ENTRY_LOG);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] base_hi_q, base_lo_q;
  logic [OFS_W-1:0]  rd_q, wr_q, mask;

  function automatic logic [OFS_W-1:0] size_mask(input logic [1:0] sz);
    logic [OFS_W-1:0] m;
    m = OFS_W'((32'd1 << (SIZE_MIN_LOG + 32'(sz))) - 32'd1);
    m[ENTRY_LOG-1:0] = '0;
    return m;
  endfunction

  assign mask = size_mask(ctrl_q.size);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
    end else begin
      if (adv_i) begin
        wr_q <= (wr_q + STEP) & mask;
        if (ovw_i) rd_q <= (rd_q + STEP) & mask;
      end
      if (drop_i) ctrl_q.ovf <= 1'b1;
      // software writes take priority over same-cycle hardware updates
      if (we_i) begin
        unique case (addr_i)
          REG_CTRL: begin
            ctrl_q.en      <= wdata_i[0];
            ctrl_q.full_en <= wdata_i[1];
            ctrl_q.irq_en  <= wdata_i[3];
            ctrl_q.stop    <= wdata_i[4];
            ctrl_q.size    <= wdata_i[9:8];
            if (wdata_i[31]) ctrl_q.ovf <= 1'b0;
          end
          REG_BASE_HI: base_hi_q <= wdata_i;
          REG_BASE_LO: base_lo_q <= wdata_i;
          REG_RD_OFS:  rd_q <= wdata_i[OFS_W-1:0] & mask;
          REG_WR_OFS:  wr_q <= wdata_i[OFS_W-1:0] & mask;
          default: ;
        endcase
      end
    end
  end

  assign en_o      = ctrl_q.en;
  assign full_en_o = ctrl_q.full_en;
  assign stop_o    = ctrl_q.stop;
  assign irq_en_o  = ctrl_q.irq_en;
  assign base_o    = ADDR_W'({base_hi_q, base_lo_q});
  assign mask_o    = mask;
  assign rd_off_o  = rd_q & mask;
  assign wr_off_o  = wr_q & mask;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[0]   = ctrl_q.en;
        rdata_o[1]   = ctrl_q.full_en;
        rdata_o[3]   = ctrl_q.irq_en;
        rdata_o[4]   = ctrl_q.stop;
        rdata_o[9:8] = ctrl_q.size;
        rdata_o[31]  = ctrl_q.ovf;
      end
      REG_BASE_HI: rdata_o = base_hi_q;
      REG_BASE_LO: rdata_o = base_lo_q;
      REG_RD_OFS:  rdata_o = DATA_W'(rd_off_o);
      REG_WR_OFS:  rdata_o = DATA_W'(wr_off_o);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/msi_ring_wr.sv
`timescale 1ns/1ps
module msi_ring_wr #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned BEAT_W    = 128,
  parameter int unsigned OFS_W     = 18,
  parameter int unsigned ENTRY_LOG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_valid_i,
  input  logic [DATA_W-1:0] msi_data_i,
  output logic              msi_ready_o,
  input  logic              en_i,
  input  logic              full_en_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  mask_i,
  input  logic [OFS_W-1:0]  rd_off_i,
  input  logic [OFS_W-1:0]  wr_off_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BEAT_W-1:0] mem_data_o,
  output logic              adv_o,
  output logic              ovw_o,
  output logic              drop_o
);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(1 << ENTRY_LOG);

  logic              busy_q, ovw_q, full, take, start;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] data_q;

  assign full   = full_en_i && (((wr_off_i + STEP) & mask_i) == rd_off_i);
  assign take   = msi_valid_i && !busy_q && en_i;
  assign drop_o = take && full && stop_i;
  assign start  = take && !(full && stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ovw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ovw_q  <= full;
      addr_q <= base_i + ADDR_W'(wr_off_i);
      data_q <= {{(BEAT_W-DATA_W){1'b0}}, msi_data_i};
    end else if (busy_q && mem_ready_i) begin
      busy_q <= 1'b0;
    end
  end

  assign msi_ready_o = !busy_q;
  assign mem_valid_o = busy_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = data_q;
  assign adv_o       = busy_q && mem_ready_i;
  assign ovw_o       = ovw_q;
endmodule

// File: rtl/msi_ring_ctrl.sv
`timescale 1ns/1ps
module msi_ring_ctrl #(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 64,
  parameter int unsigned BEAT_W       = 128,
  parameter int unsigned OFS_W        = 18,
  parameter int unsigned ENTRY_LOG    = 4,
  parameter int unsigned SIZE_MIN_LOG = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              msi_valid_i,
  input  logic [DATA_W-1:0] msi_data_i,
  output logic              msi_ready_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BEAT_W-1:0] mem_data_o,
  output logic              irq_o
);
  logic              en_w, full_en_w, stop_w, irq_en_w;
  logic              adv_w, ovw_w, drop_w;
  logic [ADDR_W-1:0] base_w;
  logic [OFS_W-1:0]  mask_w, rd_off_w, wr_off_w;

  msi_ring_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W),
    .ENTRY_LOG(ENTRY_LOG), .SIZE_MIN_LOG(SIZE_MIN_LOG)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .en_o(en_w), .full_en_o(full_en_w), .stop_o(stop_w), .irq_en_o(irq_en_w),
    .base_o(base_w), .mask_o(mask_w), .rd_off_o(rd_off_w), .wr_off_o(wr_off_w),
    .adv_i(adv_w), .ovw_i(ovw_w), .drop_i(drop_w)
  );

  msi_ring_wr #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W),
    .OFS_W(OFS_W), .ENTRY_LOG(ENTRY_LOG)
  ) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .msi_valid_i(msi_valid_i), .msi_data_i(msi_data_i), .msi_ready_o(msi_ready_o),
    .en_i(en_w), .full_en_i(full_en_w), .stop_i(stop_w),
    .base_i(base_w), .mask_i(mask_w), .rd_off_i(rd_off_w), .wr_off_i(wr_off_w),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .adv_o(adv_w), .ovw_o(ovw_w), .drop_o(drop_w)
  );

  assign irq_o = en_w && irq_en_w && (rd_off_w != wr_off_w);
endmodule

// File: rtl/msi_ring_ctrl_chk.sv
`timescale 1ns/1ps
module msi_ring_ctrl_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned BEAT_W = 128,
  parameter int unsigned OFS_W  = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic              msi_ready_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BEAT_W-1:0] mem_data_o,
  input logic              irq_o,
  input logic              en_i,
  input logic [OFS_W-1:0]  wr_off_i
);
  import msi_ring_pkg::*;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R5

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !msi_ready_o); // R5

  AST_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && mem_ready_i) && !(reg_we_i && (reg_addr_i == REG_WR_OFS || reg_addr_i == REG_CTRL))
    |=> $stable(wr_off_i)); // R5

  AST_WR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_off_i[3:0] == 4'd0); // R6

  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o); // R7

  AST_NO_START_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !mem_valid_o |=> !mem_valid_o); // R2
endmodule

bind msi_ring_ctrl msi_ring_ctrl_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .msi_ready_o(msi_ready_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .irq_o(irq_o),
  .en_i(en_w), .wr_off_i(wr_off_w)
);

// File: tb/tb_msi_ring_ctrl.sv
`timescale 1ns/1ps
module tb_msi_ring_ctrl;
  localparam logic [63:0] BASE = 64'h0000_0001_2000_0000;
  // {message data, expected record offset}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0001, 32'h0000_0000}, {32'h0000_ABCD, 32'h0000_0010},
    {32'hFFFF_1234, 32'h0000_0020}, {32'h8000_0000, 32'h0000_0030},
    {32'h0000_FFFF, 32'h0000_0040}, {32'h1234_5678, 32'h0000_0050}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msi_valid = 1'b0, msi_ready;
  logic [31:0] msi_data = '0;
  logic mem_valid, mem_ready = 1'b1, irq;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;

  logic [127:0] mem [logic [63:0]];
  int wr_cnt = 0, n_chk = 0, n_fail = 0, cnt0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  msi_ring_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .msi_valid_i(msi_valid),
    .msi_data_i(msi_data), .msi_ready_o(msi_ready), .mem_valid_o(mem_valid),
    .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .irq_o(irq));

  always @(posedge clk) if (mem_valid && mem_ready) begin
    mem[mem_addr] = mem_data;
    wr_cnt++;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // taken at first edge, handshake at second; results due at the following falling edge
  task automatic send_msi(input logic [31:0] d);
    @(negedge clk); msi_valid = 1'b1; msi_data = d;
    @(negedge clk); msi_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [127:0] rec(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 128'hX;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    foreach (VEC[i]) begin end
    for (int a = 0; a < 7; a++) begin reg_rd(3'(a), rv); chk("R1 reg", rv, 0); end
    chk("R1 irq", irq, 0);
    chk("R1 mem_valid", mem_valid, 0);

    // R3 register map
    reg_wr(3'd3, BASE[63:32]);
    reg_wr(3'd4, BASE[31:0]);
    reg_rd(3'd3, rv); chk("R3 base hi", rv, BASE[63:32]);
    reg_rd(3'd4, rv); chk("R3 base lo", rv, BASE[31:0]);
    reg_rd(3'd1, rv); chk("R3 unused", rv, 0);

    // R2 disabled: message consumed, nothing written
    send_msi(32'hDEAD);
    chk("R2 no write", wr_cnt, 0);
    reg_rd(3'd6, rv); chk("R2 wr offset", rv, 0);

    // R4 R5 R7 vector walk, 32 KB queue, enable + irq enable
    reg_wr(3'd0, 32'h9);
    for (int i = 0; i < 6; i++) begin
      send_msi(VEC[i][63:32]);
      chk("R4 record", rec(BASE + 64'(VEC[i][31:0])), {96'b0, VEC[i][63:32]});
      reg_rd(3'd6, rv); chk("R5 wr advance", rv, VEC[i][31:0] + 32'h10);
      chk("R7 irq pending", irq, 1);
      chk("R5 one write", wr_cnt, i + 1);
    end

    // R7 consume and gate
    reg_wr(3'd5, 32'h60);
    chk("R7 irq after catch-up", irq, 0);
    send_msi(32'h42);
    chk("R7 irq new entry", irq, 1);
    reg_wr(3'd0, 32'h1);
    chk("R7 irq enable off", irq, 0);
    reg_wr(3'd5, 32'h70);
    reg_wr(3'd0, 32'h9);

    // R5 stall
    mem_ready = 1'b0;
    @(negedge clk); msi_valid = 1'b1; msi_data = 32'h55;
    @(negedge clk); msi_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R5 valid held", mem_valid, 1);
      chk("R5 addr held", mem_addr, BASE + 64'h70);
      chk("R5 not ready", msi_ready, 0);
      reg_rd(3'd6, rv); chk("R5 wr held", rv, 32'h70);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    reg_rd(3'd6, rv); chk("R5 wr after ready", rv, 32'h80);
    chk("R5 valid drops", mem_valid, 0);
    chk("R4 stalled record", rec(BASE + 64'h70), 128'h55);

    // R6 wrap at end of 32 KB
    reg_wr(3'd6, 32'h7FF0);
    reg_wr(3'd5, 32'h7FF0);
    send_msi(32'h77);
    chk("R6 last slot", rec(BASE + 64'h7FF0), 128'h77);
    reg_rd(3'd6, rv); chk("R6 wrap", rv, 0);

    // R6 size field and masking
    reg_wr(3'd0, 32'h309);
    reg_wr(3'd6, 32'h3FFF5);
    reg_rd(3'd6, rv); chk("R6 256KB mask", rv, 32'h3FFF0);
    reg_wr(3'd0, 32'h009);
    reg_rd(3'd6, rv); chk("R6 masked read", rv, 32'h7FF0);
    reg_wr(3'd5, 32'h12345);
    reg_rd(3'd5, rv); chk("R6 rd masked", rv, 32'h2340);

    // R8 full with stop
    reg_wr(3'd5, 32'h100);
    reg_wr(3'd6, 32'hF0);
    reg_wr(3'd0, 32'h1B);
    cnt0 = wr_cnt;
    send_msi(32'h99);
    chk("R8 dropped", wr_cnt, cnt0);
    reg_rd(3'd6, rv); chk("R8 wr unchanged", rv, 32'hF0);
    reg_rd(3'd0, rv); chk("R8 overflow set", rv, 32'h8000_001B);
    reg_wr(3'd0, 32'h8000_001B);
    reg_rd(3'd0, rv); chk("R8 overflow cleared", rv, 32'h1B);

    // R9 full, overwrite oldest
    reg_wr(3'd0, 32'h0B);
    send_msi(32'hAA);
    chk("R9 written", rec(BASE + 64'hF0), 128'hAA);
    reg_rd(3'd6, rv); chk("R9 wr", rv, 32'h100);
    reg_rd(3'd5, rv); chk("R9 rd pushed", rv, 32'h110);
    reg_rd(3'd0, rv); chk("R9 no overflow", rv, 32'h0B);

    // R10 full detection off
    reg_wr(3'd6, 32'hF0);
    reg_wr(3'd5, 32'h100);
    reg_wr(3'd0, 32'h19);
    send_msi(32'hBB);
    chk("R10 written", rec(BASE + 64'hF0), 128'hBB);
    reg_rd(3'd5, rv); chk("R10 rd kept", rv, 32'h100);
    chk("R10 irq looks empty", irq, 0);

    // R2 irq held low while disabled
    reg_wr(3'd5, 32'h0);
    reg_wr(3'd0, 32'h8);
    chk("R2 irq disabled", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule